// File: doc/BRIEF.md
# Vector Stream Request Scheduler

This block turns a set of strided vector stream descriptors into single memory requests for a page-mode, bank-interleaved memory. Each stream slot holds a start address, a stride, an element size and an element count, and is marked as read or write. The block walks the element addresses of every loaded stream. It picks which stream gets the memory port next, using a round-robin rotation that stays on one stream for as long as that stream can keep issuing. Requests that hit the same DRAM page are therefore grouped into runs and are not interleaved element by element.

Per-stream FIFOs sit outside the block. For read streams the block sees their occupancy, and for write streams it sees a not-empty flag. It holds back a read when the FIFO has no room for the returning operand, and it holds back a write until a store operand is waiting. A plain scalar request path shares the same memory port and wins over any stream whenever the port is free. The memory port carries one request at a time and holds it until the memory acknowledges it.

Top module: `stream_issue_sched`

## Requirements
- R1: The k-th request of a stream (k counted from 0) carries address base + k*(stride << sizeLog2), truncated to the address width. sizeLog2 0..3 selects 1, 2, 4 or 8 bytes.
- R2: When the current stream cannot issue, the next stream served is the first eligible one after it in increasing slot order, wrapping from the last slot to slot 0.
- R3: After a stream is granted, it keeps being granted on every free port cycle while it still has elements and its FIFO condition holds.
- R4: A read stream issues only when its FIFO occupancy plus its in-flight reads is below DEPTH, so the occupancy never exceeds DEPTH.
- R5: A write stream issues only while its wrReady input is 1, and it issues nothing while wrReady is 0.
- R6: When scReq is high on a cycle where the port is free, the next request is the scalar one (memScalar=1, address scAddr, write flag scWe), ahead of any eligible stream. scAck pulses with the memory acknowledge of that request.
- R7: streamDone for a slot is 1 once all of its elements have been issued and, for a read stream, acknowledged. It is 0 while any element remains. Finished streams are skipped by the rotation.
- R8: Only one request is outstanding at a time. While memReq is 1 and memAck is 0, memAddr, memWe, memTag and memScalar stay stable and memReq stays 1.
- R9: After reset memReq, scAck and every streamDone bit are 0.
- R10: A stream issues exactly cfgLen requests after it is loaded, and then no more. memTag carries the slot number of each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load the descriptor of slot cfgSel |
| cfgSel | input | 4 | Slot to load |
| cfgBase | input | ADDR_W | First element address |
| cfgStride | input | ADDR_W | Stride in elements |
| cfgSize | input | 2 | log2 of element size in bytes |
| cfgLen | input | LEN_W | Number of elements |
| cfgWrite | input | 1 | 1 = write stream, 0 = read stream |
| rdLevel | input | NUM_STREAMS x LVL_W | Occupancy of each read FIFO |
| wrReady | input | NUM_STREAMS | Store operand waiting in each write FIFO |
| scReq | input | 1 | Scalar request, held until scAck |
| scAddr | input | ADDR_W | Scalar address |
| scWe | input | 1 | Scalar write flag |
| scAck | output | 1 | Scalar request acknowledged |
| memReq | output | 1 | Memory request valid |
| memAddr | output | ADDR_W | Memory request address |
| memWe | output | 1 | Memory request is a write |
| memScalar | output | 1 | Request belongs to the scalar path |
| memTag | output | 4 | Stream slot of the request |
| memAck | input | 1 | Memory accepted and completed the request |
| streamDone | output | NUM_STREAMS | Per-slot completion flags |

## Verification
The hardest case to reach from the ports is a stream that blocks on a full read FIFO while another stream is also blocked, and then both resume. It shows whether the rotation starts from the stream that was served last and not from slot 0. The bench holds the returned read operands in modelled FIFOs without draining them, until two read streams have each filled to DEPTH. It then frees both FIFOs in the same cycle and checks that the last-served stream finishes its remaining elements before the other one resumes. A scalar request raised on the same cycle that a stream is loaded checks that the scalar path wins over a stream that is eligible at once.

// File: rtl/stream_sched_pkg.sv
package stream_sched_pkg;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             issueStream;
    logic             issueScalar;
    logic [SEL_W-1:0] sel;
  } issue_strobe_t;
endpackage

// File: rtl/stream_desc_path.sv
module stream_desc_path
  import stream_sched_pkg::*;
#(
  parameter int NUM_STREAMS = 3,
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [SEL_W-1:0]       cfgSel,
  input  logic [ADDR_W-1:0]      cfgBase,
  input  logic [ADDR_W-1:0]      cfgStride,
  input  logic [1:0]             cfgSize,
  input  logic [LEN_W-1:0]       cfgLen,
  input  logic                   cfgWrite,
  input  issue_strobe_t          strobe,
  input  logic [ADDR_W-1:0]      scAddr,
  input  logic                   scWe,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   memWe,
  output logic [NUM_STREAMS-1:0] hasWork,
  output logic [NUM_STREAMS-1:0] dirWr,
  output logic [NUM_STREAMS-1:0] loaded
);
  logic [ADDR_W-1:0] nextAddr [NUM_STREAMS];
  logic [ADDR_W-1:0] step     [NUM_STREAMS];
  logic [LEN_W-1:0]  remain   [NUM_STREAMS];

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_slot
    wire loadHere  = cfgWe && (cfgSel == SEL_W'(i));
    wire issueHere = strobe.issueStream && (strobe.sel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        nextAddr[i] <= '0;
        step[i]     <= '0;
        remain[i]   <= '0;
        dirWr[i]    <= 1'b0;
        loaded[i]   <= 1'b0;
      end else if (loadHere) begin
        nextAddr[i] <= cfgBase;
        step[i]     <= cfgStride << cfgSize;
        remain[i]   <= cfgLen;
        dirWr[i]    <= cfgWrite;
        loaded[i]   <= 1'b1;
      end else if (issueHere) begin
        nextAddr[i] <= nextAddr[i] + step[i];
        remain[i]   <= remain[i] - 1'b1;
      end
    end

    assign hasWork[i] = loaded[i] && (remain[i] != '0);

    // R10: a slot is granted only while it still has elements left
    assert_grant_has_work_R10: assert property (@(posedge clk) disable iff (!rstN)
      issueHere |-> (remain[i] != '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      memWe   <= 1'b0;
    end else if (strobe.issueScalar) begin
      memAddr <= scAddr;
      memWe   <= scWe;
    end else if (strobe.issueStream) begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        if (strobe.sel == SEL_W'(i)) begin
          memAddr <= nextAddr[i];
          memWe   <= dirWr[i];
        end
      end
    end
  end
endmodule

// File: rtl/stream_issue_ctrl.sv
module stream_issue_ctrl
  import stream_sched_pkg::*;
#(
  parameter int NUM_STREAMS = 3,
  parameter int DEPTH       = 4,
  parameter int LVL_W       = $clog2(DEPTH + 1)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_STREAMS-1:0]             hasWork,
  input  logic [NUM_STREAMS-1:0]             dirWr,
  input  logic [NUM_STREAMS-1:0]             loaded,
  input  logic [NUM_STREAMS-1:0][LVL_W-1:0]  rdLevel,
  input  logic [NUM_STREAMS-1:0]             wrReady,
  input  logic                               scReq,
  input  logic                               memAck,
  output issue_strobe_t                      strobe,
  output logic                               memReq,
  output logic                               memScalar,
  output logic [SEL_W-1:0]                   memTag,
  output logic                               scAck,
  output logic [NUM_STREAMS-1:0]             streamDone
);
  localparam int SUM_W = LVL_W + 1;

  logic [SEL_W-1:0]       cur;
  logic [NUM_STREAMS-1:0] eligible;
  logic [NUM_STREAMS-1:0] inFlightRd;
  logic                   pickValid;
  logic [SEL_W-1:0]       pickIdx;
  logic                   selWrite, selWrReady;
  logic [LVL_W-1:0]       selLevel;

  always_comb begin
    for (int i = 0; i < NUM_STREAMS; i++) begin
      inFlightRd[i] = memReq && !memScalar && (memTag == SEL_W'(i)) && !dirWr[i];
      eligible[i]   = hasWork[i] &&
        (dirWr[i] ? wrReady[i]
                  : ((SUM_W'(rdLevel[i]) + SUM_W'(inFlightRd[i])) < SUM_W'(DEPTH)));
      streamDone[i] = loaded[i] && !hasWork[i] && !inFlightRd[i];
    end
  end

  // Sticky round-robin: keep the current slot, else the first eligible after it.
  always_comb begin
    pickValid = 1'b0;
    pickIdx   = cur;
    for (int off = NUM_STREAMS - 1; off >= 0; off--) begin
      int t;
      t = int'(cur) + off;
      if (t >= NUM_STREAMS) t = t - NUM_STREAMS;
      if (eligible[t]) begin
        pickValid = 1'b1;
        pickIdx   = SEL_W'(t);
      end
    end
  end

  always_comb begin
    strobe.issueScalar = !memReq && scReq;
    strobe.issueStream = !memReq && !scReq && pickValid;
    strobe.sel         = pickIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq    <= 1'b0;
      memScalar <= 1'b0;
      memTag    <= '0;
      cur       <= '0;
    end else if (!memReq) begin
      if (strobe.issueScalar) begin
        memReq    <= 1'b1;
        memScalar <= 1'b1;
      end else if (strobe.issueStream) begin
        memReq    <= 1'b1;
        memScalar <= 1'b0;
        memTag    <= strobe.sel;
        cur       <= strobe.sel;
      end
    end else if (memAck) begin
      memReq <= 1'b0;
    end
  end

  assign scAck = memReq && memAck && memScalar;

  always_comb begin
    selWrite   = 1'b0;
    selWrReady = 1'b0;
    selLevel   = '0;
    for (int i = 0; i < NUM_STREAMS; i++) begin
      if (strobe.sel == SEL_W'(i)) begin
        selWrite   = dirWr[i];
        selWrReady = wrReady[i];
        selLevel   = rdLevel[i];
      end
    end
  end

  assert_scalar_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && scReq) |=> (memReq && memScalar));
  assert_wr_operand_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueStream && selWrite) |-> selWrReady);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueStream && !selWrite) |-> (SUM_W'(selLevel) < SUM_W'(DEPTH)));
  assert_hold_tag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memTag) && $stable(memScalar)));
endmodule

// File: rtl/stream_issue_sched.sv
module stream_issue_sched
  import stream_sched_pkg::*;
#(
  parameter int NUM_STREAMS = 3,
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 8,
  parameter int DEPTH       = 4,
  parameter int LVL_W       = $clog2(DEPTH + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cfgWe,
  input  logic [SEL_W-1:0]                  cfgSel,
  input  logic [ADDR_W-1:0]                 cfgBase,
  input  logic [ADDR_W-1:0]                 cfgStride,
  input  logic [1:0]                        cfgSize,
  input  logic [LEN_W-1:0]                  cfgLen,
  input  logic                              cfgWrite,
  input  logic [NUM_STREAMS-1:0][LVL_W-1:0] rdLevel,
  input  logic [NUM_STREAMS-1:0]            wrReady,
  input  logic                              scReq,
  input  logic [ADDR_W-1:0]                 scAddr,
  input  logic                              scWe,
  output logic                              scAck,
  output logic                              memReq,
  output logic [ADDR_W-1:0]                 memAddr,
  output logic                              memWe,
  output logic                              memScalar,
  output logic [SEL_W-1:0]                  memTag,
  input  logic                              memAck,
  output logic [NUM_STREAMS-1:0]            streamDone
);
  issue_strobe_t          strobe;
  logic [NUM_STREAMS-1:0] hasWork, dirWr, loaded;

  stream_desc_path #(.NUM_STREAMS(NUM_STREAMS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_path (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgBase(cfgBase), .cfgStride(cfgStride),
    .cfgSize(cfgSize), .cfgLen(cfgLen), .cfgWrite(cfgWrite),
    .strobe(strobe), .scAddr(scAddr), .scWe(scWe),
    .memAddr(memAddr), .memWe(memWe),
    .hasWork(hasWork), .dirWr(dirWr), .loaded(loaded)
  );

  stream_issue_ctrl #(.NUM_STREAMS(NUM_STREAMS), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hasWork(hasWork), .dirWr(dirWr), .loaded(loaded),
    .rdLevel(rdLevel), .wrReady(wrReady), .scReq(scReq), .memAck(memAck),
    .strobe(strobe), .memReq(memReq), .memScalar(memScalar), .memTag(memTag),
    .scAck(scAck), .streamDone(streamDone)
  );

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWe)));
endmodule

// File: tb/tb_stream_issue_sched.sv
`timescale 1ns/1ps
module tb_stream_issue_sched;
  localparam int NS = 3;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int DEPTH = 4;
  localparam int LVW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [3:0] cfgSel = '0;
  logic [AW-1:0] cfgBase = '0, cfgStride = '0;
  logic [1:0] cfgSize = '0;
  logic [LW-1:0] cfgLen = '0;
  logic cfgWrite = 1'b0;
  logic [NS-1:0][LVW-1:0] rdLevel;
  logic [NS-1:0] wrReady;
  logic scReq = 1'b0;
  logic [AW-1:0] scAddr = '0;
  logic scWe = 1'b0;
  logic scAck, memReq, memWe, memScalar, memAck;
  logic [AW-1:0] memAddr;
  logic [3:0] memTag;
  logic [NS-1:0] streamDone;

  always #5 clk = ~clk;

  stream_issue_sched #(.NUM_STREAMS(NS), .ADDR_W(AW), .LEN_W(LW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgBase(cfgBase),
    .cfgStride(cfgStride), .cfgSize(cfgSize), .cfgLen(cfgLen), .cfgWrite(cfgWrite),
    .rdLevel(rdLevel), .wrReady(wrReady), .scReq(scReq), .scAddr(scAddr), .scWe(scWe),
    .scAck(scAck), .memReq(memReq), .memAddr(memAddr), .memWe(memWe),
    .memScalar(memScalar), .memTag(memTag), .memAck(memAck), .streamDone(streamDone)
  );

  // Memory and FIFO model
  int rdCnt [NS];
  int wrCnt [NS];
  bit holdRd = 1'b0;
  int logCnt = 0;
  logic [AW-1:0] logAddr [64];
  logic [3:0] logTag [64];
  logic logWe [64], logSc [64];
  int nChecks = 0, nFail = 0;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      rdLevel[i] = LVW'(rdCnt[i]);
      wrReady[i] = (wrCnt[i] != 0);
    end
  end

  initial begin
    memAck = 1'b0;
    for (int i = 0; i < NS; i++) begin rdCnt[i] = 0; wrCnt[i] = 0; end
  end

  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else if (memReq && memAck) begin
      memAck <= 1'b0;
      if (logCnt < 64) begin
        logAddr[logCnt] <= memAddr; logTag[logCnt] <= memTag;
        logWe[logCnt] <= memWe; logSc[logCnt] <= memScalar;
      end
      logCnt <= logCnt + 1;
      if (!memScalar) begin
        if (memWe) wrCnt[memTag] <= wrCnt[memTag] - 1;
        else if (holdRd) rdCnt[memTag] <= rdCnt[memTag] + 1;
      end
    end else memAck <= memReq;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitLog(input int target, input string req);
    int n = 0;
    while (logCnt < target && n < 2000) begin @(negedge clk); n++; end
    check(logCnt >= target, req, logCnt, target);
  endtask

  task automatic loadSlot(input int s, input logic [AW-1:0] b, input logic [AW-1:0] st,
                          input logic [1:0] sz, input int len, input bit wr);
    cfgWe = 1'b1; cfgSel = 4'(s); cfgBase = b; cfgStride = st;
    cfgSize = sz; cfgLen = LW'(len); cfgWrite = wr;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic [AW-1:0] expAddr(input logic [AW-1:0] b, input logic [AW-1:0] st,
                                            input logic [1:0] sz, input int k);
    return b + AW'(k) * (st << sz);
  endfunction

  // Table walk: base, stride, sizeLog2, length for a read stream on slot 0
  localparam logic [AW-1:0] T_BASE   [4] = '{16'h0100, 16'h0200, 16'hFFF0, 16'h0000};
  localparam logic [AW-1:0] T_STRIDE [4] = '{16'd1,    16'd3,    16'd3,    16'd0};
  localparam logic [1:0]    T_SIZE   [4] = '{2'd0,     2'd2,     2'd3,     2'd1};
  localparam int            T_LEN    [4] = '{5,        4,        3,        2};

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=done", logCnt);
    $display("%0d/%0d checks passed", nChecks + 1 - nFail, nChecks + 1);
    $finish;
  end

  initial begin
    int start;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(memReq == 1'b0, "R9 memReq", memReq, 0);
    check(scAck == 1'b0, "R9 scAck", scAck, 0);
    check(streamDone == '0, "R9 streamDone", streamDone, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R10: address sequences from the table
    for (int e = 0; e < 4; e++) begin
      start = logCnt;
      loadSlot(0, T_BASE[e], T_STRIDE[e], T_SIZE[e], T_LEN[e], 1'b0);
      waitLog(start + T_LEN[e], "R10 count reached");
      repeat (10) @(negedge clk);
      check(logCnt == start + T_LEN[e], "R10 exact count", logCnt - start, T_LEN[e]);
      for (int k = 0; k < T_LEN[e]; k++) begin
        check(logAddr[start+k] == expAddr(T_BASE[e], T_STRIDE[e], T_SIZE[e], k) &&
              logTag[start+k] == 4'd0 && !logWe[start+k] && !logSc[start+k],
              "R1 element address", logAddr[start+k],
              expAddr(T_BASE[e], T_STRIDE[e], T_SIZE[e], k));
      end
      check(streamDone[0] == 1'b1, "R7 done after table entry", streamDone[0], 1);
    end

    // R4 / R3 / R2: two read streams fill their FIFOs, then resume together
    holdRd = 1'b1;
    start = logCnt;
    loadSlot(0, 16'h1000, 16'd1, 2'd0, 6, 1'b0);
    loadSlot(1, 16'h2000, 16'd1, 2'd0, 6, 1'b0);
    waitLog(start + 8, "R4 fill");
    repeat (20) @(negedge clk);
    check(logCnt == start + 8, "R4 stop at depth", logCnt - start, 8);
    check(rdCnt[0] == DEPTH && rdCnt[1] == DEPTH, "R4 level at depth", rdCnt[0], DEPTH);
    for (int k = 0; k < 8; k++) begin
      check(logTag[start+k] == ((k < 4) ? 4'd0 : 4'd1), "R3 grouped grants",
            logTag[start+k], (k < 4) ? 0 : 1);
    end
    check(logAddr[start+4] == 16'h2000, "R1 second stream start", logAddr[start+4], 16'h2000);
    check(streamDone[0] == 1'b0, "R7 not done with elements left", streamDone[0], 0);
    rdCnt[0] = 0; rdCnt[1] = 0;
    waitLog(start + 12, "R2 resume");
    check(logTag[start+8] == 4'd1 && logTag[start+9] == 4'd1, "R2 last served first",
          logTag[start+8], 1);
    check(logTag[start+10] == 4'd0 && logTag[start+11] == 4'd0, "R2 wrap to slot 0",
          logTag[start+10], 0);
    check(logAddr[start+9] == 16'h2005 && logAddr[start+11] == 16'h1005, "R1 resumed addr",
          logAddr[start+11], 16'h1005);
    repeat (5) @(negedge clk);
    check(streamDone[1:0] == 2'b11, "R7 both done", streamDone[1:0], 3);
    rdCnt[0] = 0; rdCnt[1] = 0;

    // R5: write stream waits for operands
    start = logCnt;
    loadSlot(2, 16'h3000, 16'd2, 2'd1, 3, 1'b1);
    repeat (12) @(negedge clk);
    check(logCnt == start, "R5 no write without operand", logCnt - start, 0);
    wrCnt[2] = 2;
    waitLog(start + 2, "R5 writes");
    repeat (12) @(negedge clk);
    check(logCnt == start + 2, "R5 stop when empty", logCnt - start, 2);
    check(logWe[start] && logTag[start] == 4'd2 && logAddr[start+1] == 16'h3004,
          "R5 write addr", logAddr[start+1], 16'h3004);
    check(streamDone[2] == 1'b0, "R7 write not done", streamDone[2], 0);
    wrCnt[2] = 1;
    waitLog(start + 3, "R5 last write");
    repeat (3) @(negedge clk);
    check(logAddr[start+2] == 16'h3008, "R1 write third addr", logAddr[start+2], 16'h3008);
    check(streamDone[2] == 1'b1, "R7 write done", streamDone[2], 1);

    // R6: scalar wins over a stream loaded in the same cycle
    holdRd = 1'b0;
    start = logCnt;
    scReq = 1'b1; scAddr = 16'h5555; scWe = 1'b1;
    loadSlot(0, 16'h4000, 16'd1, 2'd2, 3, 1'b0);
    begin
      int n = 0;
      while (!scAck && n < 100) begin @(negedge clk); n++; end
      check(scAck == 1'b1, "R6 scAck seen", scAck, 1);
    end
    scReq = 1'b0;
    waitLog(start + 4, "R6 stream after scalar");
    check(logSc[start] && logAddr[start] == 16'h5555 && logWe[start], "R6 scalar first",
          logAddr[start], 16'h5555);
    check(!logSc[start+1] && logAddr[start+1] == 16'h4000 && logAddr[start+3] == 16'h4008,
          "R6 stream follows", logAddr[start+3], 16'h4008);
    repeat (10) @(negedge clk);
    check(logCnt == start + 4, "R10 no extra after scalar test", logCnt - start, 4);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule